// File: doc/BRIEF.md
# Dual-Stream Colour Router with Shared Counters

The block accepts tagged items on two independent input streams, A and B. Each item has a one-bit colour tag and a data value. An item tagged red (tag = 1) goes to the red queue of its own stream. An item tagged green (tag = 0) goes to the green queue of its own stream. Only the data value is stored. There are four internal two-entry queues in total, and each one is drained through its own valid/ready output port.

Two 16-bit counters are shared by both streams. One counts red items forwarded and the other counts green items forwarded. When both streams forward the same colour in the same cycle, the two increments are merged into one write of +2. A synchronous clear zeroes both counters and empties all four queues.

An input item moves only when it is present and its destination queue has room. The removal from the input and the write into the queue then take effect in the same cycle, or neither takes effect.

Top module: `dual_tag_router`

## Requirements
- R1: An accepted item with tag 1 (red) is stored in its own stream's red queue. An item with tag 0 (green) is stored in that stream's green queue. Only the data value is stored, and it appears unchanged on that queue's output data.
- R2: An input's ready is high exactly when the clear is low and the queue selected by the current tag holds fewer than two entries.
- R3: An item leaves an input only in a cycle where valid and ready are both high, and that same cycle writes it into a queue.
- R4: Streams A and B are independent. Both may transfer in the same cycle, each into its own queue.
- R5: When both streams forward the same colour in one cycle, that colour's counter rises by 2. When they forward different colours, each counter rises by 1. A counter does not change in a cycle with no forward of its colour.
- R6: Each queue holds at most two entries and returns them in arrival order. Output valid is high whenever at least one entry is held, and output data shows the oldest entry.
- R7: A queue accepts a write and a read in the same cycle without losing or reordering data.
- R8: While an output is valid and not ready, its valid stays high and its data stays unchanged, unless a clear occurs.
- R9: Both counters are 16 bits wide and wrap from 65535 to 0.
- R10: Reset, and a clear held for one cycle, leave both counters at 0 and all four output valids low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of counters and queues |
| a_valid | input | 1 | Stream A item present |
| a_ready | output | 1 | Stream A item will be accepted |
| a_tag | input | 1 | Stream A colour, 1 = red, 0 = green |
| a_data | input | DATA_W | Stream A value |
| b_valid | input | 1 | Stream B item present |
| b_ready | output | 1 | Stream B item will be accepted |
| b_tag | input | 1 | Stream B colour, 1 = red, 0 = green |
| b_data | input | DATA_W | Stream B value |
| ar_valid | output | 1 | Stream A red queue not empty |
| ar_ready | input | 1 | Stream A red queue read |
| ar_data | output | DATA_W | Stream A red queue head |
| ag_valid | output | 1 | Stream A green queue not empty |
| ag_ready | input | 1 | Stream A green queue read |
| ag_data | output | DATA_W | Stream A green queue head |
| br_valid | output | 1 | Stream B red queue not empty |
| br_ready | input | 1 | Stream B red queue read |
| br_data | output | DATA_W | Stream B red queue head |
| bg_valid | output | 1 | Stream B green queue not empty |
| bg_ready | input | 1 | Stream B green queue read |
| bg_data | output | DATA_W | Stream B green queue head |
| red_count | output | CNT_W | Red items forwarded |
| green_count | output | CNT_W | Green items forwarded |

## Verification
A fault in a queue slot or in a slot's valid flag shows up at the ports within a cycle or two. It appears as a wrong head value, a missing or extra output valid, or a ready that disagrees with the real fill level. A lost counter update shows up on the counter output in the very next cycle, because the expected count is tracked on every cycle. A wrong wrap width only appears after the counter passes 65535. For that reason a long stretch of red traffic from both streams pushes the red counter past that point.

// File: rtl/dual_tag_router.sv
module dual_tag_router #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic              a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic              b_tag,
  input  logic [DATA_W-1:0] b_data,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [DATA_W-1:0] ar_data,
  output logic              ag_valid,
  input  logic              ag_ready,
  output logic [DATA_W-1:0] ag_data,
  output logic              br_valid,
  input  logic              br_ready,
  output logic [DATA_W-1:0] br_data,
  output logic              bg_valid,
  input  logic              bg_ready,
  output logic [DATA_W-1:0] bg_data,
  output logic [CNT_W-1:0]  red_count,
  output logic [CNT_W-1:0]  green_count
);
  localparam int NQ = 4;

  logic [NQ-1:0]     head_v, tail_v, push, pop, drain;
  logic [DATA_W-1:0] head_d [NQ];
  logic [DATA_W-1:0] tail_d [NQ];
  logic [DATA_W-1:0] wdata  [NQ];
  logic              a_go, b_go;

  assign a_ready = !clr && (a_tag ? !tail_v[0] : !tail_v[1]);
  assign b_ready = !clr && (b_tag ? !tail_v[2] : !tail_v[3]);
  assign a_go = a_valid && a_ready;
  assign b_go = b_valid && b_ready;

  assign push  = {b_go && !b_tag, b_go && b_tag, a_go && !a_tag, a_go && a_tag};
  assign drain = {bg_ready, br_ready, ag_ready, ar_ready};
  assign pop   = drain & head_v;
  assign wdata[0] = a_data;
  assign wdata[1] = a_data;
  assign wdata[2] = b_data;
  assign wdata[3] = b_data;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head_v[q] <= 1'b0;
        tail_v[q] <= 1'b0;
      end else if (clr) begin
        head_v[q] <= 1'b0;
        tail_v[q] <= 1'b0;
      end else if (pop[q]) begin
        if (tail_v[q]) begin
          tail_v[q] <= 1'b0;
        end else begin
          head_v[q] <= push[q];
        end
      end else if (push[q]) begin
        if (head_v[q]) tail_v[q] <= 1'b1;
        else           head_v[q] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (pop[q]) begin
        if (tail_v[q])    head_d[q] <= tail_d[q];
        else if (push[q]) head_d[q] <= wdata[q];
      end else if (push[q]) begin
        if (head_v[q]) tail_d[q] <= wdata[q];
        else           head_d[q] <= wdata[q];
      end
    end
  end

  assign ar_valid = head_v[0];
  assign ag_valid = head_v[1];
  assign br_valid = head_v[2];
  assign bg_valid = head_v[3];
  assign ar_data  = head_d[0];
  assign ag_data  = head_d[1];
  assign br_data  = head_d[2];
  assign bg_data  = head_d[3];

  logic [1:0] red_step, green_step;
  assign red_step   = 2'(push[0]) + 2'(push[2]);
  assign green_step = 2'(push[1]) + 2'(push[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_count   <= '0;
      green_count <= '0;
    end else if (clr) begin
      red_count   <= '0;
      green_count <= '0;
    end else begin
      red_count   <= red_count + CNT_W'(red_step);
      green_count <= green_count + CNT_W'(green_step);
    end
  end
endmodule

// File: rtl/dual_tag_router_chk.sv
module dual_tag_router_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              a_valid,
  input logic              a_ready,
  input logic              a_tag,
  input logic              b_valid,
  input logic              b_ready,
  input logic              b_tag,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [DATA_W-1:0] ar_data,
  input logic              bg_valid,
  input logic              bg_ready,
  input logic [DATA_W-1:0] bg_data,
  input logic [CNT_W-1:0]  red_count,
  input logic [CNT_W-1:0]  green_count
);
  // R5
  red_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> red_count == CNT_W'($past(red_count)
      + CNT_W'($past(a_valid && a_ready && a_tag))
      + CNT_W'($past(b_valid && b_ready && b_tag))));

  // R5
  green_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> green_count == CNT_W'($past(green_count)
      + CNT_W'($past(a_valid && a_ready && !a_tag))
      + CNT_W'($past(b_valid && b_ready && !b_tag))));

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> red_count == '0 && green_count == '0 && !ar_valid && !bg_valid);

  // R1
  red_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_ready && a_tag |=> ar_valid);

  // R8
  hold_ar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready && !clr |=> ar_valid && $stable(ar_data));

  // R8
  hold_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bg_valid && !bg_ready && !clr |=> bg_valid && $stable(bg_data));

  // R2
  no_take_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !a_ready && !b_ready);
endmodule

bind dual_tag_router dual_tag_router_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_tag_router_bench.sv
module dual_tag_router_bench;
  localparam int DW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic a_valid = 1'b0, a_tag = 1'b0, b_valid = 1'b0, b_tag = 1'b0;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic ar_ready = 1'b0, ag_ready = 1'b0, br_ready = 1'b0, bg_ready = 1'b0;
  logic a_ready, b_ready, ar_valid, ag_valid, br_valid, bg_valid;
  logic [DW-1:0] ar_data, ag_data, br_data, bg_data;
  logic [CW-1:0] red_count, green_count;

  always #4 clk = ~clk;

  dual_tag_router #(.DATA_W(DW), .CNT_W(CW)) u_dual_tag_router (.*);

  int checks = 0;
  int fails = 0;

  int            mcnt [4];
  logic [DW-1:0] me0 [4];
  logic [DW-1:0] me1 [4];
  logic [CW-1:0] mred, mgreen;
  logic [DW-1:0] seq = 8'h11;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int q = 0; q < 4; q++) mcnt[q] = 0;
    mred = '0;
    mgreen = '0;
  endtask

  task automatic step(logic av, logic at, logic bv, logic bt, logic [3:0] rdy, logic c);
    logic [3:0] ov;
    logic [DW-1:0] od [4];
    logic er_a, er_b, fa, fb;
    int qa, qb;
    @(negedge clk);
    a_valid = av; a_tag = at; b_valid = bv; b_tag = bt; clr = c;
    a_data = seq; b_data = seq ^ 8'hA5; seq = seq + 8'd7;
    {bg_ready, br_ready, ag_ready, ar_ready} = rdy;
    #1;
    qa = at ? 0 : 1;
    qb = bt ? 2 : 3;
    er_a = !c && mcnt[qa] < 2;
    er_b = !c && mcnt[qb] < 2;
    chk("R2 a_ready", a_ready, er_a);
    chk("R2 b_ready", b_ready, er_b);
    ov = {bg_valid, br_valid, ag_valid, ar_valid};
    od[0] = ar_data; od[1] = ag_data; od[2] = br_data; od[3] = bg_data;
    for (int q = 0; q < 4; q++) begin
      chk("R6 valid", ov[q], mcnt[q] > 0);
      if (mcnt[q] > 0) chk("R1/R7 data", od[q], me0[q]);
    end
    chk("R5 red_count", red_count, mred);
    chk("R5 green_count", green_count, mgreen);
    fa = av && er_a;
    fb = bv && er_b;
    if (c) begin
      model_clear();
    end else begin
      for (int q = 0; q < 4; q++)
        if (rdy[q] && mcnt[q] > 0) begin me0[q] = me1[q]; mcnt[q]--; end
      // R3 R4: both streams may move in the same cycle
      if (fa) begin
        if (mcnt[qa] == 0) me0[qa] = a_data; else me1[qa] = a_data;
        mcnt[qa]++;
      end
      if (fb) begin
        if (mcnt[qb] == 0) me0[qb] = b_data; else me1[qb] = b_data;
        mcnt[qb]++;
      end
      mred   = mred + CW'(fa && at) + CW'(fb && bt);
      mgreen = mgreen + CW'(fa && !at) + CW'(fb && !bt);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 reset valids", {ar_valid, ag_valid, br_valid, bg_valid}, 0);
    chk("R10 reset red", red_count, 0);
    chk("R10 reset green", green_count, 0);
    rst_n = 1'b1;

    for (int pass = 0; pass < 4; pass++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] p;
        p = 8'(v * (2 * pass + 1)) ^ 8'(pass * 37);
        step(p[0], p[1], p[2], p[3], p[7:4] & ((pass == 1) ? 4'b0101 : 4'b1111),
             pass == 2 && (v % 41) == 40);
      end
    end

    // R6 R8: fill all queues without draining, then drain in order
    for (int i = 0; i < 8; i++) step(1'b1, i[0], 1'b1, ~i[0], 4'b0000, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0);

    // R10 clear
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0);
    chk("R10 clear red", red_count, 0);

    // R9 wrap: both streams red every cycle
    for (int i = 0; i < 32770; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 4'b1111, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'b1111, 1'b0);
    chk("R9 red wrap", red_count, CW'(32770 * 2));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule